// File: doc/BRIEF.md
# Descriptor Ring Poll Interval Timer

This block is a programmable periodic timer for a network controller. While it runs, it issues a one-clock poll request that tells the descriptor engine to scan its transmit and receive rings again. The time between requests comes from a 16-bit interval field. The field is written as a negative count: the timer treats it as a 17-bit two's-complement value whose top bit is always one and whose four lowest bits are always zero. One count of the field equals one half of an oscillator period. The timer counts these periods on a tick-enable input that the surrounding logic raises once per half-period.

Software controls the timer with three command inputs: halt, go and initialise. The interval field and the running poll counter can be read and written only while the timer is halted. Accesses at any other time have no effect, and reads return zero. Initialisation loads the default field value of zero, which gives the longest interval. A value that software has written since reset overrides this default, so a later initialisation does not overwrite it. Reset itself does not load the default.

Top module: `ring_poll_timer`

## Requirements
- R1: After reset the timer is halted and `poll_req` is low. An interval read returns the reset field value 0xFFF0 and a counter read returns 0x0000.
- R2: A write to the interval field (`reg_sel`=0) stores bits 15:4 of the write data and discards bits 3:0, so a later read returns those bits as zero. Writing 0xFFFF reads back as 0xFFF0.
- R3: While the timer runs, writes to either register have no effect and reads return 0x0000.
- R4: A pulse on `init_cmd` loads the field value 0x0000 when software has not written the interval since reset.
- R5: Once software has written the interval, a later `init_cmd` leaves that value unchanged.
- R6: A `start_cmd` without `stop_cmd` reloads the 17-bit counter with {1, field[15:4], 0000} and starts the timer. The first `poll_req` comes 2^17 minus the reload value ticks later. A field of 0xFFF0 gives a period of 16 ticks.
- R7: The field value 0x0000 gives a period of 65,536 ticks between starting and the first poll request.
- R8: `poll_req` is high for exactly one clock, on the clock after the tick that wraps the counter. The counter then reloads, so further requests follow every period.
- R9: While halted, the counter holds its value and no poll request is issued. If `stop_cmd` and `start_cmd` arrive together, the stop wins.
- R10: The counter advances only on clocks where `tick_en` is high. While `tick_en` is low, the counter waits and no poll request is issued.
- R11: While halted, a counter write (`reg_sel`=1) sets counter bits 15:0 and forces bit 16 to one. A counter read returns counter bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Half-oscillator-period advance enable |
| stop_cmd | input | 1 | Halt the timer; opens register access |
| start_cmd | input | 1 | Reload the counter and start timing |
| init_cmd | input | 1 | Load the default interval unless software has set one |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = interval field, 1 = poll counter |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data; zero unless a read is allowed |
| poll_req | output | 1 | One-clock ring poll request |

## Verification
A command or write presented before clock edge n takes effect at edge n, and read data is combinational, so a read is compared in the same half-cycle in which it is issued. Suppose a start is sampled at edge s+1 and ticks arrive on every clock after it. Then the first poll request is visible after edge s+1+N, where N is 2^17 minus the reload value, and each later request follows N clocks after the previous one. When ticks are held off, the first request slips by exactly the number of tick-free clocks. The driver computes these cycle numbers from the requirements and queues them. At every falling edge a monitor compares any pulse against the head of the queue, and it flags a queued cycle that passes without a pulse.

// File: rtl/ring_poll_pkg.sv
// Package: shared widths and the register select encoding for the poll timer.
// Assumes a 16-bit interval field whose low bits are ignored and a
// counter one bit wider than the field, with an implied top bit of one.
package ring_poll_pkg;
    localparam int FIELD_W  = 16;
    localparam int IGN_BITS = 4;
    localparam int CNT_W    = FIELD_W + 1;

    typedef enum logic {
        SEL_INTERVAL = 1'b0,
        SEL_COUNTER  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/ring_poll_ctrl.sv
// Module: run/halt state for the poll timer.
// Assumes commands are single-clock pulses; halt wins over go.
// Produces the counter load pulse and the per-clock advance enable.
module ring_poll_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_cmd,
    input  logic start_cmd,
    input  logic tick_en,
    output logic running,
    output logic load,
    output logic adv
);
    // Run flag: cleared by reset or halt, set by go.
    always_ff @(posedge clk) begin
        if (!rst_n)         running <= 1'b0;
        else if (stop_cmd)  running <= 1'b0;
        else if (start_cmd) running <= 1'b1;
    end

    // Load and advance strobes for the counter.
    always_comb begin
        load = start_cmd && !stop_cmd;
        adv  = running && tick_en && !stop_cmd && !start_cmd;
    end

    // R9: a halt command always leaves the timer halted.
    p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !running);
endmodule

// File: rtl/ring_poll_interval.sv
// Module: interval field storage.
// Keeps only the significant field bits; the low IGN_BITS read as zero.
// Initialisation loads INIT_FIELD until software has written a value.
// Writes are accepted only while the timer is halted.
module ring_poll_interval
    import ring_poll_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RESET_FIELD = 16'hFFF0,
    parameter logic [FIELD_W-1:0] INIT_FIELD  = 16'h0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               running,
    input  logic               init_cmd,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wdata,
    output logic [FIELD_W-1:0] field,
    output logic [CNT_W-1:0]   reload
);
    localparam int SIG_W = FIELD_W - IGN_BITS;

    logic [SIG_W-1:0] sig_q;
    logic             user_set_q;
    logic             wr_go;

    // Write qualification: only while halted.
    always_comb wr_go = wr_en && !running;

    // Field storage with software write taking priority over initialisation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q      <= RESET_FIELD[FIELD_W-1:IGN_BITS];
            user_set_q <= 1'b0;
        end else if (wr_go) begin
            sig_q      <= wdata[FIELD_W-1:IGN_BITS];
            user_set_q <= 1'b1;
        end else if (init_cmd && !user_set_q) begin
            sig_q      <= INIT_FIELD[FIELD_W-1:IGN_BITS];
        end
    end

    // Visible field and the 17-bit reload value with the implied top one.
    always_comb begin
        field  = {sig_q, {IGN_BITS{1'b0}}};
        reload = {1'b1, sig_q, {IGN_BITS{1'b0}}};
    end

    // R3: a write attempt while running leaves the field unchanged.
    p_no_wr_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en && !init_cmd) |=> $stable(field));
    // R5: once software has set a value, initialisation keeps it.
    p_init_keeps_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (user_set_q && init_cmd && !wr_en) |=> $stable(field));
endmodule

// File: rtl/ring_poll_counter.sv
// Module: 17-bit up counter that requests a poll when it wraps.
// Priority is load, then software write, then advance. A wrap pulses
// poll_req for one clock and reloads from the reload value.
module ring_poll_counter
    import ring_poll_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               adv,
    input  logic               running,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wdata,
    input  logic [CNT_W-1:0]   reload,
    output logic [CNT_W-1:0]   cnt,
    output logic               poll_req
);
    logic at_wrap;

    // Terminal count detection.
    always_comb at_wrap = (cnt == {CNT_W{1'b1}});

    // Counter update and poll pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            poll_req <= 1'b0;
        end else begin
            poll_req <= 1'b0;
            if (load) begin
                cnt <= reload;
            end else if (wr_en) begin
                cnt <= {1'b1, wdata};
            end else if (adv) begin
                if (at_wrap) begin
                    cnt      <= reload;
                    poll_req <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R8: a poll pulse follows an advancing clock and lasts one clock.
    p_poll_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> $past(adv));
    p_poll_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> !poll_req);
    // R9/R10: without an advance, load or write the count holds.
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load && !wr_en) |=> $stable(cnt));
    // R6: while running the implied top bit is always set.
    p_top_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt[CNT_W-1]);
endmodule

// File: rtl/ring_poll_timer.sv
// Top: descriptor ring poll interval timer.
// Assumes tick_en arrives once per half oscillator period.
// Register access is allowed only while the timer is halted.
module ring_poll_timer
    import ring_poll_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        stop_cmd,
    input  logic        start_cmd,
    input  logic        init_cmd,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        poll_req
);
    reg_sel_e           sel;
    logic               running, load, adv;
    logic               int_wr, cnt_wr;
    logic [FIELD_W-1:0] field;
    logic [CNT_W-1:0]   reload, cnt;

    // Decode register select and the write strobes.
    always_comb begin
        sel    = reg_sel_e'(reg_sel);
        int_wr = reg_wr_en && (sel == SEL_INTERVAL);
        cnt_wr = reg_wr_en && (sel == SEL_COUNTER) && !running;
    end

    ring_poll_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_cmd  (stop_cmd),
        .start_cmd (start_cmd),
        .tick_en   (tick_en),
        .running   (running),
        .load      (load),
        .adv       (adv)
    );

    ring_poll_interval u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .init_cmd (init_cmd),
        .wr_en    (int_wr),
        .wdata    (reg_wdata),
        .field    (field),
        .reload   (reload)
    );

    ring_poll_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .running  (running),
        .wr_en    (cnt_wr),
        .wdata    (reg_wdata),
        .reload   (reload),
        .cnt      (cnt),
        .poll_req (poll_req)
    );

    // Read mux: zero unless a read is made while halted.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd_en && !running)
            reg_rdata = (sel == SEL_COUNTER) ? cnt[FIELD_W-1:0] : field;
    end

    // R1: no poll request while the timer is halted.
    p_no_poll_halted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !$past(running)) |-> !poll_req);
endmodule

// File: tb/ring_poll_timer_tb_top.sv
// Scoreboard bench: the driver queues expected poll cycles, the monitor matches pulses.
module ring_poll_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1, stop_cmd = 1'b0, start_cmd = 1'b0, init_cmd = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        poll_req;

    int unsigned cyc = 0;
    int          n_chk = 0, n_bad = 0;
    int unsigned exp_q[$];
    bit          done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ring_poll_timer dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Monitor: compare each pulse against the queue head; flag missed pulses.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (poll_req) begin
                if (exp_q.size() == 0) chk(1'b0, "R8 unexpected poll", int'(cyc), 0);
                else begin
                    chk(exp_q[0] == cyc, "R6/R8 poll timing", int'(cyc), int'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
            end else if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                chk(1'b0, "R6/R7 missing poll", int'(cyc), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic rd(input logic sel, input logic [15:0] exp, input string tag);
        reg_sel = sel; reg_rd_en = 1'b1;
        #1;
        chk(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
        reg_rd_en = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic go(output int unsigned s);
        @(negedge clk); start_cmd = 1'b1; s = cyc;
        @(negedge clk); start_cmd = 1'b0;
    endtask

    task automatic halt();
        @(negedge clk); stop_cmd = 1'b1;
        @(negedge clk); stop_cmd = 1'b0;
    endtask

    task automatic init();
        @(negedge clk); init_cmd = 1'b1;
        @(negedge clk); init_cmd = 1'b0;
    endtask

    // Driver
    initial begin
        int unsigned s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(poll_req == 1'b0, "R1 poll low", poll_req, 0);
        rd(1'b0, 16'hFFF0, "R1 interval reset value");
        rd(1'b1, 16'h0000, "R1 counter reset value");

        init();
        rd(1'b0, 16'h0000, "R4 init loads default");

        // R7: default interval, 65536 ticks
        go(s);
        exp_q.push_back(s + 1 + 65536);
        while (cyc < s + 65536 + 8) @(negedge clk);
        halt();

        wr(1'b0, 16'hFFFF);
        rd(1'b0, 16'hFFF0, "R2 low nibble ignored");
        init();
        rd(1'b0, 16'hFFF0, "R5 init keeps user value");

        // R6/R8: 16-tick period, three pulses; R3 access while running
        go(s);
        for (int k = 1; k <= 3; k++) exp_q.push_back(s + 1 + 16 * k);
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'h0000);
        @(negedge clk);
        rd(1'b0, 16'h0000, "R3 read while running");
        while (cyc < s + 55) @(negedge clk);
        halt();
        rd(1'b0, 16'hFFF0, "R3 write ignored while running");

        // R11 counter access, R9 hold while halted
        wr(1'b1, 16'h1234);
        rd(1'b1, 16'h1234, "R11 counter write/read");
        repeat (50) @(negedge clk);
        rd(1'b1, 16'h1234, "R9 counter holds while halted");

        // R10: ticks withheld for 100 clocks after start
        tick_en = 1'b0;
        go(s);
        while (cyc < s + 100) @(negedge clk);
        tick_en = 1'b1;
        exp_q.push_back(s + 116);
        while (cyc < s + 120) @(negedge clk);
        tick_en = 1'b0;
        halt();

        // R9: simultaneous stop and start stays halted
        go(s);
        @(negedge clk); stop_cmd = 1'b1; start_cmd = 1'b1;
        @(negedge clk); stop_cmd = 1'b0; start_cmd = 1'b0;
        rd(1'b0, 16'hFFF0, "R9 stop wins over start");
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all polls seen", exp_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog expired", int'(cyc), 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule